// File: doc/BRIEF.md
# Scalar Register File with Hardwired Zero

This block is the general-purpose register storage of a scalar datapath. It holds sixty-four 64-bit registers and serves two operand reads together with one result write in each clock cycle. The reads are combinational. A write commits on the rising clock edge. A read that targets the register being written in the same cycle still sees the value from before the write.

Each port carries a width flag. A narrow (32-bit) write stores the low half of the incoming word and fills the upper half with copies of bit 31, whatever the incoming upper bits hold. A narrow read looks only at the low half of the stored register and returns it sign-extended. Register 0 is a constant zero: it reads as zero on both ports and swallows any write.

The block also inspects the two source designators of each access. It raises a combinational flag when the two designators name registers that are exactly 32 apart. The flag only reports the pairing. Both reads are still performed, and the write goes ahead as usual.

Top module: `scalar_rf`

## Requirements
- R1: A synchronous active-high reset clears every register, so after reset every read on either port returns 0.
- R2: A wide write (`wr_wide`=1) with `wr_en`=1 to a nonzero register stores all 64 bits of `wr_data`, and a wide read returns them from the next cycle on.
- R3: Register 0 reads as 0 on both ports at all times, and writes addressed to it have no effect of either width.
- R4: A narrow write (`wr_wide`=0) stores `wr_data[31:0]` in bits 31:0, with bits 63:32 all equal to `wr_data[31]`; the incoming `wr_data[63:32]` is ignored.
- R5: A narrow read (`rd_wide_x`=0) returns the stored bits 31:0 in bits 31:0, with bits 63:32 all equal to stored bit 31.
- R6: A read of the register being written in the same cycle returns the value held before that write.
- R7: `pair_illegal` is 1 exactly when `rd_addr_a` and `rd_addr_b` differ by 32 (same low five bits, different bit 5), is combinational, and never blocks the reads or the write.
- R8: With `wr_en`=0 no register changes, whatever the other write inputs are.
- R9: The two read ports are independent: each returns its own register in its own width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit sign-filled write |
| wr_addr | input | 6 | Destination register |
| wr_data | input | 64 | Write value |
| rd_addr_a | input | 6 | Source register, port A |
| rd_wide_a | input | 1 | 1 = 64-bit read, 0 = 32-bit sign-extended read, port A |
| rd_data_a | output | 64 | Read value, port A |
| rd_addr_b | input | 6 | Source register, port B |
| rd_wide_b | input | 1 | 1 = 64-bit read, 0 = 32-bit sign-extended read, port B |
| rd_data_b | output | 64 | Read value, port B |
| pair_illegal | output | 1 | Source designators are exactly 32 apart |

## Verification
A wrong stored word stays hidden until that register is read on a port, so a corrupt write, a dropped write or a write that leaks into register 0 shows up only on the first later read of the affected entry. The bench therefore reads every register right after reset and keeps reading random registers throughout the run, in both widths. A fault in the narrow path, such as bad sign filling on write or on read, appears in the upper 32 bits on the first access of the wrong width. Faults in the pairing flag and in the same-cycle read ordering are visible in the very cycle of the access.

// File: rtl/scalar_rf_pkg.sv
package scalar_rf_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  // Replicate bit HALF_W-1 of a word across its upper half.
  function automatic word_t sext_low(input word_t v);
    half_t lo;
    lo = v[HALF_W-1:0];
    return {{HALF_W{lo[HALF_W-1]}}, lo};
  endfunction

  // Width-selected view of a word: wide passes through, narrow sign-extends.
  function automatic word_t width_view(input word_t v, input logic wide);
    return wide ? v : sext_low(v);
  endfunction

  // Two designators clash when they differ only in their top bit.
  function automatic logic halves_clash(input logic [7:0] a, input logic [7:0] b,
                                        input int unsigned aw);
    logic [7:0] diff;
    logic [7:0] low_mask;
    diff     = a ^ b;
    low_mask = 8'((1 << (aw - 1)) - 1);
    return ((diff & low_mask) == 8'd0) && diff[aw-1];
  endfunction

endpackage

// File: rtl/rf_write_fmt.sv
module rf_write_fmt
  import scalar_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  output logic              commit,
  output word_t             commit_data
);

  // Writes addressed to register 0 never reach storage.
  assign commit      = wr_en && (wr_addr != '0);
  assign commit_data = width_view(wr_data, wr_wide);

endmodule

// File: rtl/rf_store.sv
module rf_store
  import scalar_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            commit,
  input  logic [ADDR_W-1:0]               commit_addr,
  input  word_t                           commit_data,
  input  logic                            commit_wide,
  output logic [(1<<ADDR_W)-1:0][WORD_W-1:0] regs
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (commit) begin
      regs[commit_addr] <= commit_data;
    end
  end

  AST_ENTRY0_ZERO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> regs[0] == '0); // R3

  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(regs)); // R8

  AST_WIDE_LANDS: assert property (@(posedge clk) disable iff (rst)
    commit && commit_wide |=> regs[$past(commit_addr)] == $past(commit_data)); // R2

  AST_NARROW_FILLED: assert property (@(posedge clk) disable iff (rst)
    commit && !commit_wide |=>
      regs[$past(commit_addr)][WORD_W-1:HALF_W] == {HALF_W{regs[$past(commit_addr)][HALF_W-1]}}); // R4

  initial begin
    if (DEPTH < 2) $error("rf_store: depth too small");
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import scalar_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [(1<<ADDR_W)-1:0][WORD_W-1:0] regs,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic                            rd_wide,
  output word_t                           rd_data
);

  word_t raw;

  always_comb begin
    raw = regs[rd_addr];
    if (rd_addr == '0) raw = '0;
  end

  assign rd_data = width_view(raw, rd_wide);

  AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_addr == '0 |-> rd_data == '0); // R3

  AST_NARROW_READ_SEXT: assert property (@(posedge clk) disable iff (rst)
    !rd_wide |-> rd_data[WORD_W-1:HALF_W] == {HALF_W{rd_data[HALF_W-1]}}); // R5

  AST_LOW_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
    rd_addr != '0 |-> rd_data[HALF_W-1:0] == regs[rd_addr][HALF_W-1:0]); // R5

endmodule

// File: rtl/rf_pair_check.sv
module rf_pair_check
  import scalar_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] src_a,
  input  logic [ADDR_W-1:0] src_b,
  output logic              clash
);

  assign clash = halves_clash(8'(src_a), 8'(src_b), ADDR_W);

  AST_SAME_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
    src_a == src_b |-> !clash); // R7

  AST_CLASH_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
    clash |-> src_a[ADDR_W-1] != src_b[ADDR_W-1]); // R7

  initial begin
    if (ADDR_W < 2 || ADDR_W > 8) $error("rf_pair_check: ADDR_W out of range");
  end

endmodule

// File: rtl/scalar_rf.sv
module scalar_rf
  import scalar_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic              rd_wide_a,
  output logic [63:0]       rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic              rd_wide_b,
  output logic [63:0]       rd_data_b,
  output logic              pair_illegal
);

  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned N_READS = 2;

  // Named internal events for the assertions.
  logic                          wr_commit;
  word_t                         wr_word;
  logic [DEPTH-1:0][WORD_W-1:0]  regs;

  logic [N_READS-1:0][ADDR_W-1:0] rd_addr_v;
  logic [N_READS-1:0]             rd_wide_v;
  word_t                          rd_data_v [N_READS];

  assign rd_addr_v = {rd_addr_b, rd_addr_a};
  assign rd_wide_v = {rd_wide_b, rd_wide_a};

  rf_write_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .wr_en       (wr_en),
    .wr_wide     (wr_wide),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .commit      (wr_commit),
    .commit_data (wr_word)
  );

  rf_store #(.ADDR_W(ADDR_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .commit      (wr_commit),
    .commit_addr (wr_addr),
    .commit_data (wr_word),
    .commit_wide (wr_wide),
    .regs        (regs)
  );

  for (genvar p = 0; p < N_READS; p++) begin : g_rd
    rf_read_port #(.ADDR_W(ADDR_W)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .regs    (regs),
      .rd_addr (rd_addr_v[p]),
      .rd_wide (rd_wide_v[p]),
      .rd_data (rd_data_v[p])
    );
  end

  assign rd_data_a = rd_data_v[0];
  assign rd_data_b = rd_data_v[1];

  rf_pair_check #(.ADDR_W(ADDR_W)) u_pair (
    .clk   (clk),
    .rst   (rst),
    .src_a (rd_addr_a),
    .src_b (rd_addr_b),
    .clash (pair_illegal)
  );

  AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == '0 |-> !wr_commit); // R3

  AST_OLD_VALUE_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_commit && rd_wide_a && rd_addr_a == wr_addr |=> $past(rd_data_a) == $past(regs[rd_addr_a])); // R6

  AST_FLAG_KEEPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    pair_illegal && wr_commit && wr_wide |=> regs[$past(wr_addr)] == $past(wr_data)); // R7

endmodule

// File: tb/test_scalar_rf.sv
`timescale 1ns/1ps
module test_scalar_rf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_wide = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [5:0]  rd_addr_a = '0;
  logic        rd_wide_a = 1'b1;
  logic [63:0] rd_data_a;
  logic [5:0]  rd_addr_b = '0;
  logic        rd_wide_b = 1'b1;
  logic [63:0] rd_data_b;
  logic        pair_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] model [64];

  always #2 clk = ~clk;

  scalar_rf i_scalar_rf (
    .clk (clk), .rst (rst),
    .wr_en (wr_en), .wr_wide (wr_wide), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr_a (rd_addr_a), .rd_wide_a (rd_wide_a), .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b), .rd_wide_b (rd_wide_b), .rd_data_b (rd_data_b),
    .pair_illegal (pair_illegal)
  );

  function automatic logic [63:0] exp_narrow(input logic [63:0] v);
    logic signed [31:0] s;
    logic signed [63:0] w;
    s = v[31:0];
    w = s;
    return w;
  endfunction

  function automatic logic [63:0] exp_read(input int a, input logic wide);
    if (a == 0) return 64'd0;
    return wide ? model[a] : exp_narrow(model[a]);
  endfunction

  function automatic logic exp_pair(input int a, input int b);
    return (a - b == 32) || (b - a == 32);
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle: inputs set after a falling edge, reads checked
  // before the rising edge (old contents), model updated at the edge.
  task automatic cycle(input string tag_a, input string tag_b, input logic en, input logic wide,
                       input int wa, input logic [63:0] wd,
                       input int ra, input logic wa_w, input int rb, input logic wb_w);
    wr_en = en; wr_wide = wide; wr_addr = 6'(wa); wr_data = wd;
    rd_addr_a = 6'(ra); rd_wide_a = wa_w; rd_addr_b = 6'(rb); rd_wide_b = wb_w;
    #1;
    check64(tag_a, rd_data_a, exp_read(ra, wa_w));
    check64(tag_b, rd_data_b, exp_read(rb, wb_w));
    check64("R7", {63'd0, pair_illegal}, {63'd0, exp_pair(ra, rb)});
    @(posedge clk);
    if (en && wa != 0) model[wa] = wide ? wd : exp_narrow(wd);
    @(negedge clk);
  endtask

  initial begin
    #(4.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
    for (int i = 0; i < 64; i++) model[i] = 64'hDEAD_BEEF_0BAD_F00D;
    // drive garbage writes during reset; reset must win
    wr_en = 1'b1; wr_wide = 1'b1; wr_addr = 6'd9; wr_data = 64'h1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = '0;

    // R1: every register clear after reset, both ports
    for (int i = 0; i < 64; i++)
      cycle("R1", "R1", 1'b0, 1'b1, 0, 64'hFFFF, i, 1'b1, 63 - i, 1'b0);

    // R3: writes to register 0 of both widths are dropped
    cycle("R3", "R3", 1'b1, 1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1, 0, 1'b0);
    cycle("R3", "R3", 1'b1, 1'b0, 0, 64'h0000_0000_8000_0001, 0, 1'b1, 0, 1'b0);
    cycle("R3", "R3", 1'b0, 1'b1, 0, 64'd0, 0, 1'b1, 0, 1'b0);

    // R2 wide write, R6 same-cycle read shows old value
    cycle("R6", "R6", 1'b1, 1'b1, 7, 64'hA5A5_0000_8765_4321, 7, 1'b1, 7, 1'b0);
    cycle("R2", "R5", 1'b0, 1'b1, 0, 64'd0, 7, 1'b1, 7, 1'b0);

    // R4: narrow write sign-fills, ignores incoming upper half
    cycle("R4", "R4", 1'b1, 1'b0, 12, 64'h0123_4567_8000_0000, 1, 1'b1, 2, 1'b1);
    cycle("R4", "R4", 1'b1, 1'b0, 13, 64'hFFFF_FFFF_7FFF_FFFF, 12, 1'b1, 12, 1'b0);
    cycle("R4", "R9", 1'b0, 1'b0, 13, 64'd0, 13, 1'b1, 12, 1'b1);

    // R8: disabled write with live data leaves register untouched
    cycle("R8", "R8", 1'b0, 1'b1, 13, 64'hCAFE_CAFE_CAFE_CAFE, 13, 1'b1, 13, 1'b0);
    cycle("R8", "R8", 1'b0, 1'b0, 13, 64'd0, 13, 1'b1, 12, 1'b1);

    // R7: pairings 32 apart flagged; access still performed
    cycle("R7", "R7", 1'b1, 1'b1, 37, 64'h5555_0000_FFFF_0001, 5, 1'b1, 37, 1'b1);
    cycle("R7", "R7", 1'b0, 1'b1, 0, 64'd0, 37, 1'b1, 5, 1'b1);
    cycle("R7", "R7", 1'b0, 1'b1, 0, 64'd0, 0, 1'b1, 32, 1'b1);
    cycle("R7", "R7", 1'b0, 1'b1, 0, 64'd0, 63, 1'b0, 31, 1'b1);
    cycle("R7", "R7", 1'b0, 1'b1, 0, 64'd0, 5, 1'b1, 36, 1'b1);
    cycle("R7", "R7", 1'b0, 1'b1, 0, 64'd0, 20, 1'b1, 20, 1'b1);

    // Random traffic: R2/R5/R9 reads, R6 collisions, R3 zero, R4 narrow writes
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] d;
      int wa, ra, rb;
      logic ww, aw, bw;
      d  = {$urandom, $urandom};
      wa = int'($urandom_range(0, 63));
      ra = ($urandom_range(0, 3) == 0) ? wa : int'($urandom_range(0, 63));
      rb = ($urandom_range(0, 7) == 0) ? (ra ^ 32) : int'($urandom_range(0, 63));
      ww = 1'($urandom); aw = 1'($urandom); bw = 1'($urandom);
      cycle(aw ? "R2" : "R5", bw ? "R9" : "R5", 1'($urandom_range(0, 3) != 0), ww,
            wa, d, ra, aw, rb, bw);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule